// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit resolves read-after-write data hazards in a five-stage in-order pipeline. For the instruction in the execute stage it chooses the source of each ALU operand. An operand comes from the register file value latched at decode, unless a newer result for the same register is still travelling through the memory or writeback stage. In that case the newer result is bypassed straight to the operand multiplexer, before it has been written back.

One case cannot be bypassed. A load in execute has no data yet while the next instruction, still in decode, needs it. For that case the unit raises a hold for the program counter and the fetch/decode register. In the same cycle it raises a squash for the decode/execute register. The squash clears only that register's write-enable and memory controls, so the slot behaves as a nop. One cycle later the load has reached the memory stage and its data reaches the dependent instruction through the writeback bypass. No bypass from writeback to decode exists, because the register file writes in the first half of the cycle and reads in the second.

The unit is purely combinational. Its outputs are valid in the same cycle as its inputs.

Top module: `fwd_interlock_unit`

## Requirements
- R1: An operand select is 2'b00 (register file) when no enabled, non-zero producer destination matches that operand's source register. The value 2'b11 never appears.
- R2: An operand select is 2'b10 when the memory-stage producer has its write enable high, a non-zero destination, and that destination equals the operand's source.
- R3: An operand select is 2'b01 when the writeback-stage producer qualifies in the same way and the memory-stage producer does not.
- R4: When both producers qualify for the same operand, the memory-stage (younger) result wins with 2'b10.
- R5: Register 0 is never bypassed: a source of 0 always yields 2'b00.
- R6: A producer whose write enable is low never causes a bypass, even when its destination matches.
- R7: A load in execute with a non-zero destination equal to either decode-stage source raises both the front-end hold and the execute squash in the same cycle.
- R8: No hold or squash is raised in three cases: the execute instruction is not a load, its destination is 0, or neither decode source matches it.
- R9: The two operand selects are decided independently, each from its own source register.
- R10: The front-end hold and the execute squash are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_ADDR_W | First source register of the instruction in execute |
| ex_src_b | input | REG_ADDR_W | Second source register of the instruction in execute |
| mem_dst | input | REG_ADDR_W | Destination of the instruction in the memory stage |
| mem_wr_en | input | 1 | Register write enable of the memory-stage instruction |
| wb_dst | input | REG_ADDR_W | Destination of the instruction in writeback |
| wb_wr_en | input | 1 | Register write enable of the writeback instruction |
| ex_dst | input | REG_ADDR_W | Destination of the instruction in execute |
| ex_is_load | input | 1 | High when the execute instruction is a load |
| id_src_a | input | REG_ADDR_W | First source register of the instruction in decode |
| id_src_b | input | REG_ADDR_W | Second source register of the instruction in decode |
| fwd_sel_a | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 writeback |
| fwd_sel_b | output | 2 | Operand B select, same encoding |
| hold_front | output | 1 | Holds the PC and the fetch/decode register |
| squash_ex | output | 1 | Clears the write and memory controls entering execute |

## Verification
The bench builds the unit with REG_ADDR_W = 3, which gives eight registers. With that width the bypass sweep covers every source, both producer destinations and every write-enable pairing, including register 0 and double matches. The interlock sweep covers every execute destination, the load flag and every pair of decode sources. Operand B is driven with a source offset from operand A, so each vector checks the two selects against different match conditions.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WBACK   = 2'b01,
    SEL_MEMSTG  = 2'b10
  } opnd_sel_e;
endpackage

// File: rtl/producer_match.sv
// One comparator: does a producer that writes a non-zero register feed this source?
module producer_match #(
  parameter int W = 5
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic         wr_en,
  output logic         hit
);
  always_comb begin
    hit = wr_en && (dst != '0) && (dst == src);
  end
endmodule

// File: rtl/operand_route.sv
module operand_route
  import fwd_pkg::*;
#(
  parameter int W = 5
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] mem_dst,
  input  logic         mem_wr_en,
  input  logic [W-1:0] wb_dst,
  input  logic         wb_wr_en,
  output opnd_sel_e    sel
);
  logic hit_mem;
  logic hit_wb;

  producer_match #(.W(W)) u_mem (.src(src), .dst(mem_dst), .wr_en(mem_wr_en), .hit(hit_mem));
  producer_match #(.W(W)) u_wb  (.src(src), .dst(wb_dst),  .wr_en(wb_wr_en),  .hit(hit_wb));

  // younger producer first
  always_comb begin
    if (hit_mem)     sel = SEL_MEMSTG;
    else if (hit_wb) sel = SEL_WBACK;
    else             sel = SEL_REGFILE;
  end

  always_comb begin
    if (sel == SEL_MEMSTG)
      assert_memsel_source_R2: assert (mem_wr_en && mem_dst == src)
        else $error("memory-stage select without matching enabled producer");
    if (sel == SEL_WBACK)
      assert_wbsel_source_R3: assert (wb_wr_en && wb_dst == src)
        else $error("writeback select without matching enabled producer");
    if (src == '0)
      assert_zero_not_bypassed_R5: assert (sel == SEL_REGFILE)
        else $error("register 0 bypassed");
  end
endmodule

// File: rtl/load_use_guard.sv
module load_use_guard #(
  parameter int W    = 5,
  parameter int NSRC = 2
) (
  input  logic [W-1:0]           ex_dst,
  input  logic                   ex_is_load,
  input  logic [NSRC-1:0][W-1:0] id_src,
  output logic                   stall
);
  logic [NSRC-1:0] src_hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    producer_match #(.W(W)) u_cmp (
      .src  (id_src[i]),
      .dst  (ex_dst),
      .wr_en(ex_is_load),
      .hit  (src_hit[i])
    );
  end

  always_comb begin
    stall = |src_hit;
  end

  always_comb begin
    if (stall)
      assert_stall_needs_load_R7: assert (ex_is_load && ex_dst != '0)
        else $error("stall without a load in execute");
    if (!ex_is_load)
      assert_no_stall_nonload_R8: assert (!stall)
        else $error("stall raised for a non-load");
  end
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
  import fwd_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] ex_src_a,
  input  logic [REG_ADDR_W-1:0] ex_src_b,
  input  logic [REG_ADDR_W-1:0] mem_dst,
  input  logic                  mem_wr_en,
  input  logic [REG_ADDR_W-1:0] wb_dst,
  input  logic                  wb_wr_en,
  input  logic [REG_ADDR_W-1:0] ex_dst,
  input  logic                  ex_is_load,
  input  logic [REG_ADDR_W-1:0] id_src_a,
  input  logic [REG_ADDR_W-1:0] id_src_b,
  output logic [1:0]            fwd_sel_a,
  output logic [1:0]            fwd_sel_b,
  output logic                  hold_front,
  output logic                  squash_ex
);
  localparam int NOPND = 2;

  logic [NOPND-1:0][REG_ADDR_W-1:0] ex_srcs;
  logic [NOPND-1:0][REG_ADDR_W-1:0] id_srcs;
  opnd_sel_e                        sels [NOPND];
  logic                             lu_stall;

  assign ex_srcs = {ex_src_b, ex_src_a};
  assign id_srcs = {id_src_b, id_src_a};

  for (genvar k = 0; k < NOPND; k++) begin : g_opnd
    operand_route #(.W(REG_ADDR_W)) u_route (
      .src      (ex_srcs[k]),
      .mem_dst  (mem_dst),
      .mem_wr_en(mem_wr_en),
      .wb_dst   (wb_dst),
      .wb_wr_en (wb_wr_en),
      .sel      (sels[k])
    );
  end

  load_use_guard #(.W(REG_ADDR_W), .NSRC(NOPND)) u_guard (
    .ex_dst    (ex_dst),
    .ex_is_load(ex_is_load),
    .id_src    (id_srcs),
    .stall     (lu_stall)
  );

  always_comb begin
    fwd_sel_a  = sels[0];
    fwd_sel_b  = sels[1];
    hold_front = lu_stall;
    squash_ex  = lu_stall;
  end

  always_comb begin
    assert_sel_legal_R1: assert (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11)
      else $error("illegal operand select");
    assert_hold_squash_pair_R10: assert (hold_front == squash_ex)
      else $error("hold and squash disagree");
    if (!mem_wr_en && !wb_wr_en)
      assert_no_enable_no_bypass_R6: assert (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00)
        else $error("bypass without any write enable");
  end
endmodule

// File: tb/fwd_interlock_unit_test.sv
module fwd_interlock_unit_test;
  localparam int W = 3;
  localparam int NREG = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst, ex_dst, id_src_a, id_src_b;
  logic mem_wr_en, wb_wr_en, ex_is_load;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic hold_front, squash_ex;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  fwd_interlock_unit #(.REG_ADDR_W(W)) uut (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
    .wb_dst(wb_dst), .wb_wr_en(wb_wr_en),
    .ex_dst(ex_dst), .ex_is_load(ex_is_load),
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .hold_front(hold_front), .squash_ex(squash_ex)
  );

  function automatic logic [1:0] want_sel(int src, int md, int mwe, int wd, int wwe);
    if (mwe != 0 && md != 0 && md == src) return 2'b10;  // R2, R4
    if (wwe != 0 && wd != 0 && wd == src) return 2'b01;  // R3
    return 2'b00;                                        // R1, R5, R6
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0; ex_dst = '0;
    id_src_a = '0; id_src_b = '0;
    mem_wr_en = 1'b0; wb_wr_en = 1'b0; ex_is_load = 1'b0;
  endtask

  initial begin
    clear_inputs();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state after reset: no bypass, no stall
    check("R1 idle sel_a", fwd_sel_a, 2'b00);
    check("R1 idle sel_b", fwd_sel_b, 2'b00);
    check("R8 idle hold", {1'b0, hold_front}, 2'b00);
    check("R10 idle squash", {1'b0, squash_ex}, 2'b00);

    // bypass sweep: R1 R2 R3 R4 R5 R6, operand B offset for R9
    for (int md = 0; md < NREG; md++)
      for (int wd = 0; wd < NREG; wd++)
        for (int we = 0; we < 4; we++)
          for (int s = 0; s < NREG; s++) begin
            @(posedge clk);
            mem_dst = W'(md); wb_dst = W'(wd);
            mem_wr_en = we[0]; wb_wr_en = we[1];
            ex_src_a = W'(s);
            ex_src_b = W'((s + 3) % NREG);
            @(negedge clk);
            check("R2/R3/R4 sel_a", fwd_sel_a, want_sel(s, md, we & 1, wd, we >> 1));
            check("R9 sel_b", fwd_sel_b,
                  want_sel((s + 3) % NREG, md, we & 1, wd, we >> 1));
          end

    // explicit corner: both stages match, younger wins
    @(posedge clk);
    mem_dst = 3'd5; wb_dst = 3'd5; mem_wr_en = 1'b1; wb_wr_en = 1'b1;
    ex_src_a = 3'd5; ex_src_b = 3'd0;
    @(negedge clk);
    check("R4 double match", fwd_sel_a, 2'b10);
    check("R5 zero source", fwd_sel_b, 2'b00);

    // interlock sweep: R7 R8 R10
    @(posedge clk);
    clear_inputs();
    for (int d = 0; d < NREG; d++)
      for (int ld = 0; ld < 2; ld++)
        for (int a = 0; a < NREG; a++)
          for (int b = 0; b < NREG; b++) begin
            logic exp_st;
            @(posedge clk);
            ex_dst = W'(d); ex_is_load = ld[0];
            id_src_a = W'(a); id_src_b = W'(b);
            exp_st = (ld != 0) && (d != 0) && (d == a || d == b);
            @(negedge clk);
            check("R7/R8 hold", {1'b0, hold_front}, {1'b0, exp_st});
            check("R10 squash", {1'b0, squash_ex}, {1'b0, exp_st});
          end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule